// File: doc/BRIEF.md
# Interrupt Entry Sequencer with Tail-Chaining

This block sequences interrupt entry and exit for a small processor. It watches a vector of level-sensitive request lines and picks the lowest-numbered one. It then plays out a fixed, cycle-counted entry: a context-save window, a vector-fetch window and a one-cycle handler-entry pulse. After that it waits in the handler until software signals the end with a return pulse. If another line is pending at that return, the block takes a short chained path straight into the next handler and skips the restore/save pair. Otherwise it runs a context-restore window and goes back to idle.

With auto-sleep enabled, a return that leaves nothing pending puts the block to sleep with no software action. It then raises a sleep request and drops its clock-enable output, so the main sequencer stops getting clock edges. A small wake detector runs on a separate always-on clock. It sees any request line while the main clock is stopped, raises a wake request and re-enables the clock. The pending line is then serviced through the normal entry path.

No data flows through this block. Every pin is a plain control or status signal with no valid/ready handshake, and there is no back-pressure.

Top module: `irq_seq`

## Requirements
- R1: After reset `phase` reads 0 (idle), `clk_en` is 1, and `sleep_req`, `wake_req`, `stack_stb`, `unstack_stb`, `vec_fetch` and `hdl_enter` are 0.
- R2: When a request is accepted, `hdl_id` takes the index of the lowest-numbered asserted `irq_req` bit, which has the highest priority.
- R3: `hdl_enter` is a one-cycle pulse that is high exactly ENTRY_CYC (12) cycles after the clock edge at which the request was accepted. During entry, `stack_stb` is high for the first ENTRY_CYC-VEC_CYC (8) cycles and `vec_fetch` for the last VEC_CYC (4).
- R4: A request that arrives during the entry sequence does not change `hdl_id` or the entry timing. It stays pending.
- R5: While no `hdl_ret` pulse arrives, the block stays in the handler phase (2) with `hdl_id` unchanged.
- R6: If a line is pending at the edge where `hdl_ret` is sampled, `phase` becomes 3 (chaining), `hdl_enter` pulses exactly CHAIN_CYC (6) cycles after that edge, and `hdl_id` is the lowest pending line.
- R7: On the chained path neither `stack_stb` nor `unstack_stb` is asserted, and `vec_fetch` is high for the last VEC_CYC (4) cycles.
- R8: If nothing is pending at `hdl_ret`, `phase` is 4 (returning) with `unstack_stb` high for EXIT_CYC (8) cycles. After that it is idle, or entering if a line became pending.
- R9: With `sleep_on_exit` high, a return that ends with nothing pending leads to `phase` 5 (asleep), `sleep_req` 1 and `clk_en` 0. These hold while no line is asserted.
- R10: While asleep, an asserted `irq_req` line raises `wake_req` and `clk_en` one always-on clock cycle later. The line is then taken through the normal ENTRY_CYC entry.
- R11: `clk_en` is 0 only when `phase` is 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Gated main clock of the sequencer |
| aon_clk | input | 1 | Always-on clock of the wake detector |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | N_IRQ | Level request lines, bit 0 highest priority |
| hdl_ret | input | 1 | One-cycle pulse: the running handler has finished |
| sleep_on_exit | input | 1 | Enables automatic sleep after the last handler |
| stack_stb | output | 1 | Context-save window during entry |
| vec_fetch | output | 1 | Vector-fetch window during entry or chaining |
| unstack_stb | output | 1 | Context-restore window on return |
| hdl_enter | output | 1 | One-cycle pulse: first handler instruction |
| hdl_id | output | IDW | Line number of the handler being entered or run |
| phase | output | 3 | 0 idle, 1 entering, 2 handler, 3 chaining, 4 returning, 5 asleep |
| sleep_req | output | 1 | Request to the power controller to sleep |
| wake_req | output | 1 | Wake request from the always-on detector |
| clk_en | output | 1 | Enable for the main clock gate |

## Verification
On every cycle, the assertions check the priority of the latched line, the exact length of the entry and chaining phases, the absence of save/restore strobes while chaining, that the clock gate is closed only in sleep, that the handler phase is held without a return pulse, and that a wake request rises only from sleep. Only the bench scenarios can show the full request-to-handler and return-to-handler latencies as seen at the pins. The same holds for the hold-off of a request that arrives mid-entry, the descent into sleep with the main clock really stopped, and wake-up followed by a normal entry. Randomized request masks exercise long chains, in which each hop must pick the lowest remaining line.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_ENTER   = 3'd1,
    PH_HANDLER = 3'd2,
    PH_CHAIN   = 3'd3,
    PH_RETURN  = 3'd4,
    PH_SLEEP   = 3'd5
  } phase_t;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N_IRQ = 8,
  localparam int IDW = $clog2(N_IRQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] req,
  output logic             any,
  output logic [IDW-1:0]   win
);
  always_comb begin
    win = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (req[i]) win = IDW'(i);
    end
  end
  assign any = |req;

  // R2
  prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (req[win] && ((req & ((N_IRQ'(1) << win) - N_IRQ'(1))) == '0)));
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
#(
  parameter int N_IRQ     = 8,
  parameter int ENTRY_CYC = 12,
  parameter int CHAIN_CYC = 6,
  parameter int VEC_CYC   = 4,
  parameter int EXIT_CYC  = 8,
  localparam int IDW = $clog2(N_IRQ),
  localparam int MAXC = (ENTRY_CYC > EXIT_CYC) ? ENTRY_CYC : EXIT_CYC,
  localparam int CW = $clog2(MAXC + 1),
  localparam int STACK_CYC = ENTRY_CYC - VEC_CYC
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pend,
  input  logic [IDW-1:0] win,
  input  logic           hdl_ret,
  input  logic           sleep_on_exit,
  output phase_t         st,
  output logic [IDW-1:0] id,
  output logic           hdl_enter,
  output logic           stack_stb,
  output logic           vec_fetch,
  output logic           unstack_stb
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= PH_IDLE;
      cnt       <= '0;
      id        <= '0;
      hdl_enter <= 1'b0;
    end else begin
      hdl_enter <= 1'b0;
      case (st)
        PH_IDLE, PH_SLEEP: begin
          if (pend) begin
            st  <= PH_ENTER;
            cnt <= '0;
            id  <= win;
          end
        end
        PH_ENTER: begin
          if (cnt == CW'(ENTRY_CYC - 1)) begin
            st        <= PH_HANDLER;
            hdl_enter <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_HANDLER: begin
          if (hdl_ret) begin
            cnt <= '0;
            if (pend) begin
              st <= PH_CHAIN;
              id <= win;
            end else begin
              st <= PH_RETURN;
            end
          end
        end
        PH_CHAIN: begin
          if (cnt == CW'(CHAIN_CYC - 1)) begin
            st        <= PH_HANDLER;
            hdl_enter <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_RETURN: begin
          if (cnt == CW'(EXIT_CYC - 1)) begin
            cnt <= '0;
            if (pend) begin
              st <= PH_ENTER;
              id <= win;
            end else if (sleep_on_exit) begin
              st <= PH_SLEEP;
            end else begin
              st <= PH_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= PH_IDLE;
      endcase
    end
  end

  assign stack_stb   = (st == PH_ENTER) && (cnt < CW'(STACK_CYC));
  assign vec_fetch   = ((st == PH_ENTER) && (cnt >= CW'(STACK_CYC))) ||
                       ((st == PH_CHAIN) && (cnt >= CW'(CHAIN_CYC - VEC_CYC)));
  assign unstack_stb = (st == PH_RETURN);

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_HANDLER && !hdl_ret) |=> (st == PH_HANDLER && $stable(id)));
endmodule

// File: rtl/irq_wake_det.sv
module irq_wake_det #(
  parameter int N_IRQ = 8
) (
  input  logic             aon_clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic             sleep_req,
  output logic             wake_req,
  output logic             clk_en
);
  always_ff @(posedge aon_clk or negedge rst_n) begin
    if (!rst_n) wake_req <= 1'b0;
    else        wake_req <= sleep_req && (|irq_req);
  end

  assign clk_en = !sleep_req || wake_req;

  // R10
  wake_from_sleep_chk: assert property (@(posedge aon_clk) disable iff (!rst_n)
    $rose(wake_req) |-> sleep_req);
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_seq_pkg::*;
#(
  parameter int N_IRQ     = 8,
  parameter int ENTRY_CYC = 12,
  parameter int CHAIN_CYC = 6,
  parameter int VEC_CYC   = 4,
  parameter int EXIT_CYC  = 8,
  localparam int IDW = $clog2(N_IRQ)
) (
  input  logic             clk,
  input  logic             aon_clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic             hdl_ret,
  input  logic             sleep_on_exit,
  output logic             stack_stb,
  output logic             vec_fetch,
  output logic             unstack_stb,
  output logic             hdl_enter,
  output logic [IDW-1:0]   hdl_id,
  output logic [2:0]       phase,
  output logic             sleep_req,
  output logic             wake_req,
  output logic             clk_en
);
  logic           pend;
  logic [IDW-1:0] win;
  phase_t         st;

  irq_prio_enc #(.N_IRQ(N_IRQ)) u_enc (
    .clk(clk), .rst_n(rst_n), .req(irq_req), .any(pend), .win(win)
  );

  irq_seq_fsm #(
    .N_IRQ(N_IRQ), .ENTRY_CYC(ENTRY_CYC), .CHAIN_CYC(CHAIN_CYC),
    .VEC_CYC(VEC_CYC), .EXIT_CYC(EXIT_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .pend(pend), .win(win), .hdl_ret(hdl_ret),
    .sleep_on_exit(sleep_on_exit), .st(st), .id(hdl_id), .hdl_enter(hdl_enter),
    .stack_stb(stack_stb), .vec_fetch(vec_fetch), .unstack_stb(unstack_stb)
  );

  assign phase     = st;
  assign sleep_req = (st == PH_SLEEP);

  irq_wake_det #(.N_IRQ(N_IRQ)) u_wake (
    .aon_clk(aon_clk), .rst_n(rst_n), .irq_req(irq_req),
    .sleep_req(sleep_req), .wake_req(wake_req), .clk_en(clk_en)
  );

  // Phase-length observer used only by the checks below
  phase_t      phase_q;
  logic [15:0] seg_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      seg_len <= '0;
    end else begin
      phase_q <= st;
      seg_len <= (st != phase_q) ? 16'd1 : seg_len + 16'd1;
    end
  end

  // R3
  entry_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_HANDLER && phase_q == PH_ENTER) |-> (seg_len == 16'(ENTRY_CYC) && hdl_enter));

  // R6
  chain_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_HANDLER && phase_q == PH_CHAIN) |-> (seg_len == 16'(CHAIN_CYC) && hdl_enter));

  // R7
  chain_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_CHAIN) |-> (!stack_stb && !unstack_stb));

  // R11
  gate_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |-> (st == PH_SLEEP));
endmodule

// File: tb/test_irq_seq.sv
module test_irq_seq;
  localparam int N = 8;
  localparam int IDW = $clog2(N);

  logic aon_clk = 1'b0;
  logic gate = 1'b1;
  logic clk;
  logic rst_n = 1'b0;
  logic [N-1:0] irq_req = '0;
  logic hdl_ret = 1'b0;
  logic sleep_on_exit = 1'b0;
  logic stack_stb, vec_fetch, unstack_stb, hdl_enter;
  logic [IDW-1:0] hdl_id;
  logic [2:0] phase;
  logic sleep_req, wake_req, clk_en;

  int tests = 0;
  int fails = 0;

  always #5 aon_clk = ~aon_clk;
  always @(negedge aon_clk) gate <= clk_en;
  assign clk = aon_clk & gate;

  irq_seq #(.N_IRQ(N)) i_irq_seq (
    .clk(clk), .aon_clk(aon_clk), .rst_n(rst_n), .irq_req(irq_req),
    .hdl_ret(hdl_ret), .sleep_on_exit(sleep_on_exit), .stack_stb(stack_stb),
    .vec_fetch(vec_fetch), .unstack_stb(unstack_stb), .hdl_enter(hdl_enter),
    .hdl_id(hdl_id), .phase(phase), .sleep_req(sleep_req),
    .wake_req(wake_req), .clk_en(clk_en)
  );

  function automatic int lowest(logic [N-1:0] m);
    for (int i = 0; i < N; i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Waits for hdl_enter; lat counts clock edges after the first sampled cycle.
  task automatic wait_enter(output int lat, output int stk, output int vec);
    int n = 0;
    stk = 0; vec = 0;
    forever begin
      @(negedge aon_clk);
      n++;
      if (stack_stb) stk++;
      if (vec_fetch) vec++;
      if (hdl_enter || n > 200) break;
    end
    lat = n - 1;
  endtask

  // Pulses hdl_ret and follows the resulting chain or return.
  task automatic do_ret(output int first_ph, output int lat, output int stk,
                        output int unstk, output int vec);
    int n = 0;
    stk = 0; unstk = 0; vec = 0; first_ph = -1;
    hdl_ret = 1'b1;
    forever begin
      @(negedge aon_clk);
      if (n == 0) begin
        hdl_ret = 1'b0;
        first_ph = phase;
      end
      n++;
      if (stack_stb) stk++;
      if (unstack_stb) unstk++;
      if (vec_fetch) vec++;
      if (hdl_enter) break;
      if (first_ph == 4 && phase != 3'd4) break;
      if (n > 200) break;
    end
    lat = n - 1;
  endtask

  initial begin
    repeat (200000) @(posedge aon_clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int lat, stk, vec, unstk, fp, hold_bad;
    logic [N-1:0] m;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge aon_clk);
    // R1 reset state
    chk(phase == 3'd0, "R1 phase", phase, 0);
    chk(clk_en && !sleep_req && !wake_req, "R1 power pins", {clk_en, sleep_req, wake_req}, 3'b100);
    chk(!stack_stb && !unstack_stb && !vec_fetch && !hdl_enter, "R1 strobes",
        {stack_stb, unstack_stb, vec_fetch, hdl_enter}, 0);
    rst_n = 1'b1;
    @(negedge aon_clk);

    // R3 single line entry timing and strobe windows
    irq_req = 8'b0000_1000;
    wait_enter(lat, stk, vec);
    chk(lat == 12, "R3 entry latency", lat, 12);
    chk(stk == 8, "R3 stack cycles", stk, 8);
    chk(vec == 4, "R3 vector cycles", vec, 4);
    chk(hdl_id == 3, "R2 single id", hdl_id, 3);

    // R5 no return pulse: handler held
    hold_bad = 0;
    repeat (50) begin
      @(negedge aon_clk);
      if (phase != 3'd2 || hdl_id != 3) hold_bad++;
    end
    chk(hold_bad == 0, "R5 handler hold", hold_bad, 0);

    // R8 return with nothing pending
    irq_req = '0;
    do_ret(fp, lat, stk, unstk, vec);
    chk(fp == 4, "R8 returning phase", fp, 4);
    chk(unstk == 8, "R8 unstack cycles", unstk, 8);
    chk(phase == 3'd0, "R8 back to idle", phase, 0);

    // R4 request arriving during entry is held off
    irq_req = 8'b0010_0000;
    repeat (3) @(negedge aon_clk);
    irq_req[1] = 1'b1;
    wait_enter(lat, stk, vec);
    chk(lat == 9, "R4 entry timing unchanged", lat, 9);
    chk(hdl_id == 5, "R4 id latched at accept", hdl_id, 5);

    // R6/R7 chain into the held line
    irq_req[5] = 1'b0;
    do_ret(fp, lat, stk, unstk, vec);
    chk(fp == 3, "R6 chaining phase", fp, 3);
    chk(lat == 6, "R6 chain latency", lat, 6);
    chk(hdl_id == 1, "R6 chained id", hdl_id, 1);
    chk(stk == 0 && unstk == 0, "R7 no save/restore", stk + unstk, 0);
    chk(vec == 4, "R7 chain vector cycles", vec, 4);

    // R9 sleep on exit
    irq_req = '0;
    sleep_on_exit = 1'b1;
    do_ret(fp, lat, stk, unstk, vec);
    chk(phase == 3'd5, "R9 asleep phase", phase, 5);
    chk(sleep_req && !clk_en, "R9 gate closed", {sleep_req, clk_en}, 2'b10);
    repeat (6) @(negedge aon_clk);
    chk(phase == 3'd5 && !wake_req && !clk_en, "R11 stays gated", {phase, wake_req, clk_en}, 5 << 2);

    // R10 wake by always-on detector
    irq_req = 8'b0100_0000;
    @(negedge aon_clk);
    chk(wake_req && clk_en, "R10 wake raised", {wake_req, clk_en}, 3);
    chk(phase == 3'd5, "R10 still asleep before clock", phase, 5);
    wait_enter(lat, stk, vec);
    chk(lat == 12, "R10 normal entry after wake", lat, 12);
    chk(hdl_id == 6, "R10 id after wake", hdl_id, 6);
    sleep_on_exit = 1'b0;
    irq_req = '0;
    do_ret(fp, lat, stk, unstk, vec);
    chk(phase == 3'd0 && clk_en, "R11 idle with clock", {phase, clk_en}, 1);

    // Random masks: priority, entry and chain latencies
    for (int r = 0; r < 25; r++) begin
      m = N'($urandom_range(1, (1 << N) - 1));
      irq_req = m;
      wait_enter(lat, stk, vec);
      chk(lat == 12, "R3 random entry", lat, 12);
      chk(hdl_id == lowest(m), "R2 random priority", hdl_id, lowest(m));
      while (m != '0) begin
        m[hdl_id] = 1'b0;
        irq_req = m;
        do_ret(fp, lat, stk, unstk, vec);
        if (m != '0) begin
          chk(fp == 3 && lat == 6, "R6 random chain", lat, 6);
          chk(hdl_id == lowest(m), "R6 random chain id", hdl_id, lowest(m));
          chk(stk + unstk == 0, "R7 random chain quiet", stk + unstk, 0);
        end else begin
          chk(fp == 4 && unstk == 8 && phase == 3'd0, "R8 random return", unstk, 8);
        end
      end
      repeat ($urandom_range(0, 3)) @(negedge aon_clk);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule